// File: doc/BRIEF.md
# Sinusoidal Switching-Current Load

This block draws a supply current whose size follows a sine wave at a frequency set by a tuning word. It does this without any analog output. A bank of identical toggle flip-flops shares the supply rail, and on every fast clock edge a varying number of them flip. Each flip charges or discharges a node, so the total current on that edge follows the count of cells that switched. A phase accumulator walks a sine table. Each table entry is an unsigned count between 0 and the number of cells. That count becomes a thermometer-coded enable vector, so the cells that switch are always the lowest-numbered ones.

The load is meant to run only while a supply-impedance measurement is being taken, next to the normal functional logic. When it is idle it draws no modulated current. Every activation starts from phase zero, so repeated measurements line up with each other. A new tuning word written while the load is running is held back until the current sine period ends, so no period is ever cut short. Keep the cell count modest, because the injected current has to stay small-signal.

Top module: `sine_load_gen`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released with act_i low, cells_o is all zeros and busy_o is 0.
- R2: busy_o equals the value act_i had at the previous rising clock edge.
- R3: On each rising edge, cell k of cells_o inverts if and only if k < L and act_i is high at that edge. L is the level registered on the previous edge, and L is 0 when act_i was low on the previous edge. Cells that are not enabled hold their value.
- R4: The table index is the top LUT_AW bits of the phase. With h = 2^(LUT_AW-1), j = idx mod h, q = j*(h-j), d = 5*h*h - 4*q and s = floor((N/2*16*q + d/2)/d), the level is N/2 + s for idx < h and N/2 - s otherwise.
- R5: On each edge with act_i high, the phase advances by the active tuning word modulo 2^PHASE_W. The level registered on that edge is the table entry for the phase value held before the advance.
- R6: An edge with act_i low toggles no cell, clears the phase and clears the registered level. After re-activation, the first active edge toggles nothing and the second toggles N/2 cells (table index 0).
- R7: While act_i is low, the active tuning word tracks ftw_i on every edge. While act_i is high, it loads ftw_i only on an edge where the phase addition carries out of PHASE_W bits, and holds its value on every other edge.
- R8: The registered level never exceeds N_CELLS. N_CELLS must be even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast load clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Run the load while high |
| ftw_i | input | PHASE_W | Frequency tuning word, phase step per clock |
| cells_o | output | N_CELLS | Outputs of the toggle cell bank |
| busy_o | output | 1 | High while the load is running |

## Verification
The bench uses a word of one table step per clock to walk every sine entry twice, which checks each level and its thermometer mask. A quarter-period word and a half-period word hit the peak, the trough and the repeated mid-level entries. An odd word with a large step exercises phase wrap-around at irregular positions. A tuning change made in mid-period tells a hold-until-wrap design apart from one that applies the word at once. Dropping act_i in mid-wave and raising it again separates a design that resumes from the old phase from one that restarts at index zero.

// File: rtl/sine_load_pkg.sv
package sine_load_pkg;

  // Sine level, offset to 0..n, rational approximation of sin over a half period
  function automatic int sine_level(int idx, int aw, int n);
    int h, j, q, d, s;
    h = 1 << (aw - 1);
    j = idx % h;
    q = j * (h - j);
    d = 5 * h * h - 4 * q;
    s = ((n / 2) * 16 * q + d / 2) / d;
    return (idx < h) ? (n / 2 + s) : (n / 2 - s);
  endfunction

endpackage

// File: rtl/sload_phase.sv
module sload_phase #(
  parameter int PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] ftw_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] ftw_o
);
  logic [PHASE_W-1:0] phase_q, ftw_q;
  logic [PHASE_W:0]   sum;

  assign sum = {1'b0, phase_q} + {1'b0, ftw_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      ftw_q   <= '0;
    end else if (!run_i) begin
      phase_q <= '0;
      ftw_q   <= ftw_i;
    end else begin
      phase_q <= sum[PHASE_W-1:0];
      if (sum[PHASE_W]) ftw_q <= ftw_i;  // retune only at period end
    end
  end

  assign phase_o = phase_q;
  assign ftw_o   = ftw_q;
endmodule

// File: rtl/sload_rom.sv
module sload_rom #(
  parameter int LUT_AW  = 8,
  parameter int N_CELLS = 64,
  parameter int LVL_W   = 7
) (
  input  logic [LUT_AW-1:0] idx_i,
  output logic [LVL_W-1:0]  level_o
);
  localparam int DEPTH = 1 << LUT_AW;

  logic [LVL_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = LVL_W'(sine_load_pkg::sine_level(g, LUT_AW, N_CELLS));
  end

  assign level_o = rom[idx_i];
endmodule

// File: rtl/sload_thermo.sv
module sload_thermo #(
  parameter int N_CELLS = 64,
  parameter int LVL_W   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [LVL_W-1:0]   level_i,
  output logic [LVL_W-1:0]   level_o,
  output logic [N_CELLS-1:0] en_o
);
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     level_q <= '0;
    else if (!run_i) level_q <= '0;
    else             level_q <= level_i;
  end

  for (genvar k = 0; k < N_CELLS; k++) begin : g_therm
    assign en_o[k] = (level_q > LVL_W'(k));
  end

  assign level_o = level_q;
endmodule

// File: rtl/sload_cells.sv
module sload_cells #(
  parameter int N_CELLS = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [N_CELLS-1:0] en_i,
  output logic [N_CELLS-1:0] cells_o
);
  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cell_q <= 1'b0;
      else if (run_i && en_i[k])  cell_q <= ~cell_q;
    end
    assign cells_o[k] = cell_q;
  end
endmodule

// File: rtl/sine_load_gen.sv
module sine_load_gen #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 8,
  parameter int N_CELLS = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               act_i,
  input  logic [PHASE_W-1:0] ftw_i,
  output logic [N_CELLS-1:0] cells_o,
  output logic               busy_o
);
  localparam int LVL_W = $clog2(N_CELLS + 1);

  logic [PHASE_W-1:0] phase_q, ftw_q;
  logic [LVL_W-1:0]   rom_level, level_q;
  logic [N_CELLS-1:0] en_q;
  logic               busy_q;

  sload_phase #(.PHASE_W(PHASE_W)) i_phase (
    .clk_i, .rst_ni, .run_i(act_i), .ftw_i,
    .phase_o(phase_q), .ftw_o(ftw_q)
  );

  sload_rom #(.LUT_AW(LUT_AW), .N_CELLS(N_CELLS), .LVL_W(LVL_W)) i_rom (
    .idx_i(phase_q[PHASE_W-1 -: LUT_AW]), .level_o(rom_level)
  );

  sload_thermo #(.N_CELLS(N_CELLS), .LVL_W(LVL_W)) i_thermo (
    .clk_i, .rst_ni, .run_i(act_i), .level_i(rom_level),
    .level_o(level_q), .en_o(en_q)
  );

  sload_cells #(.N_CELLS(N_CELLS)) i_cells (
    .clk_i, .rst_ni, .run_i(act_i), .en_i(en_q), .cells_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= act_i;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/sine_load_gen_chk.sv
module sine_load_gen_chk #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 8,
  parameter int N_CELLS = 64,
  parameter int LVL_W   = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               act_i,
  input logic               busy_o,
  input logic [N_CELLS-1:0] cells_o,
  input logic [N_CELLS-1:0] en_q,
  input logic [LVL_W-1:0]   level_q,
  input logic [PHASE_W-1:0] phase_q,
  input logic [PHASE_W-1:0] ftw_q
);
  logic [PHASE_W:0] nxt;
  assign nxt = {1'b0, phase_q} + {1'b0, ftw_q};

  // R2
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> busy_o);
  // R2
  busy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> !busy_o);
  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> ($stable(cells_o) && en_q == '0 && phase_q == '0));
  // R3
  toggle_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> ((cells_o ^ $past(cells_o)) == $past(en_q)));
  // R3
  thermo_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q + 1'b1) & en_q) == '0);
  // R5
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (phase_q == $past(nxt[PHASE_W-1:0])));
  // R7
  ftw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !nxt[PHASE_W]) |=> $stable(ftw_q));
  // R8
  level_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(level_q) <= N_CELLS);
endmodule

bind sine_load_gen sine_load_gen_chk #(
  .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .N_CELLS(N_CELLS), .LVL_W(LVL_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act_i), .busy_o(busy_o),
  .cells_o(cells_o), .en_q(en_q), .level_q(level_q),
  .phase_q(phase_q), .ftw_q(ftw_q)
);

// File: tb/test_sine_load_gen.sv
module test_sine_load_gen;
  localparam int PW = 32;
  localparam int AW = 8;
  localparam int N  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act = 1'b0;
  logic [PW-1:0] ftw = '0;
  logic [N-1:0]  cells;
  logic          busy;

  always #4 clk = ~clk;  // 125 MHz

  sine_load_gen #(.PHASE_W(PW), .LUT_AW(AW), .N_CELLS(N)) i_sine_load_gen (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act), .ftw_i(ftw),
    .cells_o(cells), .busy_o(busy)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [PW-1:0] m_phase = '0, m_ftw = '0;
  int            m_lvl = 0;
  logic [N-1:0]  prev = '0;

  // R4: expected table level, from the stated formula
  function automatic int ref_level(int idx);
    int h, j, q, d, s;
    h = 1 << (AW - 1);
    j = idx % h;
    q = j * (h - j);
    d = 5 * h * h - 4 * q;
    s = ((N / 2) * 16 * q + d / 2) / d;
    return (idx < h) ? (N / 2 + s) : (N / 2 - s);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic step(string tag);
    int           exp_tog;
    logic [PW:0]  s;
    logic [N-1:0] diff, emask;
    @(posedge clk);
    if (act) begin
      exp_tog = m_lvl;
      m_lvl   = ref_level(int'(m_phase[PW-1 -: AW]));
      s       = {1'b0, m_phase} + {1'b0, m_ftw};
      m_phase = s[PW-1:0];
      if (s[PW]) m_ftw = ftw;  // R7
    end else begin
      exp_tog = 0;
      m_lvl   = 0;
      m_phase = '0;
      m_ftw   = ftw;
    end
    @(negedge clk);
    diff  = cells ^ prev;
    emask = (N'(1) << exp_tog) - N'(1);  // R3 R8 thermometer of width <= N
    n_vec++;
    if (diff !== emask) begin
      n_bad++;
      $display("FAIL %s R3: toggled %h expected %h", tag, diff, emask);
    end
    n_vec++;
    if (busy !== act) begin
      n_bad++;
      $display("FAIL R2: busy %b expected %b", busy, act);
    end
    prev = cells;
  endtask

  task automatic run(string tag, logic [PW-1:0] w, int cyc);
    ftw = w;
    act = 1'b1;
    for (int i = 0; i < cyc; i++) step(tag);
  endtask

  task automatic idle(int cyc);
    act = 1'b0;
    for (int i = 0; i < cyc; i++) step("R6");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run ended %0d expected 0", 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    n_vec++;
    if (cells !== '0 || busy !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: cells %h busy %b expected 0 0", cells, busy);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (cells !== '0 || busy !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: cells %h busy %b expected 0 0", cells, busy);
    end
    prev = cells;

    idle(3);
    run("R4", 32'h0100_0000, 520);      // every entry, twice
    idle(2);
    run("R5", 32'h4000_0000, 12);       // quarter steps: mid, peak, mid, trough
    run("R5", 32'h8000_0000, 8);        // half steps, retuned at wrap
    run("R5", 32'h0300_0000, 150);
    idle(3);                            // drop mid-wave
    run("R6", 32'h0300_0000, 20);       // restart from index 0
    idle(1);
    run("R7", 32'h1000_0000, 5);
    run("R7", 32'h0800_0000, 60);       // change mid-period, held to wrap
    run("R7", 32'h0000_0000, 30);       // frozen phase after wrap
    idle(2);
    run("R5", 32'h1234_5679, 400);      // irregular wrap points
    idle(3);
    finish_run();
  end
endmodule